// File: doc/BRIEF.md
# Shared Timer Prescaler with Synchronized Hold and Release

This block generates the count-enable strobes for two timer/counters that draw their divided clocks from one shared 10-bit prescaler. Each timer picks its clock source with a 3-bit select code. The choices are stopped, every system clock, one of four divided taps, or the falling or rising edges of its own external pin. Each pin is brought into the clock domain by a two-stage synchronizer and a registered edge detector. The timer counters themselves sit outside this block and advance on the strobes.

A one-byte control register is written and read through a simple write-strobe port. Bit 0 restarts the shared prescaler. Bit 1 drives the reset output of a second, separate prescaler, which appears here only as that output. Bit 7 selects synchronization mode. With bit 7 clear, a written reset bit lasts one cycle and then clears itself. With bit 7 set, the written reset bits are kept, so both timers stay halted while software sets them up. Writing bit 7 back to zero clears both reset bits, and both timers resume prescaled counting on the same clock edge.

The control logic is a three-state machine. `CTL_FREE` means no reset bit is active. `CTL_PULSE` means a reset bit was written with sync mode off and clears on the next cycle. `CTL_HOLD` means sync mode is on. A write goes to `CTL_HOLD` when bit 7 is 1. Otherwise it goes to `CTL_PULSE` when bit 0 or bit 1 is 1, and to `CTL_FREE` when both are 0. With no write, `CTL_PULSE` returns to `CTL_FREE`, and the other two states stay where they are.

Top module: `tmr_prescale_top`

## Requirements
- R1: After reset the control byte reads 0x00, both count enables are 0 and the second-prescaler reset output is 0.
- R2: Control byte layout: bit 7 = sync mode, bit 1 = second-prescaler reset, bit 0 = shared-prescaler reset. Bits 6 to 2 always read 0, and writing them has no effect.
- R3: With sync mode 0, a reset bit written as 1 reads 1 for exactly one cycle and then reads 0. A shared reset restarts the prescaler, so every divided tap strobes on the cycle the bit clears.
- R4: With sync mode 1, written reset bits are kept unchanged until the next write.
- R5: While the shared reset bit is 1, both count enables are 0 for every select code, external codes included.
- R6: Writing a byte with bit 7 = 0 while holding clears both reset bits. Both timers on divided taps then strobe together in the first cycle after that write edge.
- R7: Select codes: 0 never strobes, 1 strobes every cycle, and 2, 3, 4, 5 strobe once every 8, 64, 256 and 1024 cycles respectively.
- R8: Select code 7 strobes once per rising edge of the timer's pin and code 6 once per falling edge. The strobe appears in the cycle after the third rising clock edge following the pin change, and never in two consecutive cycles.
- R9: The second-prescaler reset output equals bit 1 of the control byte and has no effect on either timer's strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control byte read data |
| clk_sel_a | input | 3 | Clock select code, timer A |
| clk_sel_b | input | 3 | Clock select code, timer B |
| ext_pin | input | 2 | External clock pins (bit 0 timer A, bit 1 timer B) |
| cnt_en | output | 2 | Count-enable strobes (bit 0 timer A, bit 1 timer B) |
| aux_pre_rst | output | 1 | Reset for the second prescaler |

## Verification
A wrong control state is visible on `reg_rdata` in the cycle after the faulty write or clear. One example is a hold that decays, or a pulse that sticks. A prescaler that fails to restart or release shows up as tap strobes shifted from the expected cycle. That shift appears within 8 cycles on the divide-by-8 tap and within 1024 cycles on the slowest tap. Faults in the synchronizer chain show as strobes one cycle early or late after a pin edge, or as a missing or doubled strobe per edge.

// File: rtl/tps_pkg.sv
package tps_pkg;

    typedef enum logic [2:0] {
        SEL_STOP     = 3'd0,
        SEL_CLK      = 3'd1,
        SEL_D8       = 3'd2,
        SEL_D64      = 3'd3,
        SEL_D256     = 3'd4,
        SEL_D1024    = 3'd5,
        SEL_EXT_FALL = 3'd6,
        SEL_EXT_RISE = 3'd7
    } clk_sel_e;

    typedef enum logic [1:0] {
        CTL_FREE  = 2'd0,
        CTL_PULSE = 2'd1,
        CTL_HOLD  = 2'd2
    } ctl_state_e;

    localparam int BIT_SYNC = 7;
    localparam int BIT_AUX  = 1;
    localparam int BIT_SHR  = 0;
    localparam int NUM_TAPS = 4;
    localparam int NUM_TMR  = 2;
    localparam int SEL_W    = 3;

    // low-bit width whose wrap to zero marks each divided tap
    function automatic int tap_width(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tps_ctrl_fsm.sv
module tps_ctrl_fsm
    import tps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       wr_sync,
    input  logic [1:0] wr_rst,
    output logic [7:0] rdata,
    output logic       shr_rst,
    output logic       aux_rst
);

    ctl_state_e state_q, state_d;
    logic [1:0] bits_q, bits_d;

    // next-state and reset-bit selection
    always_comb begin
        state_d = state_q;
        bits_d  = bits_q;
        if (wr) begin
            bits_d = wr_rst;
            if (wr_sync)
                state_d = CTL_HOLD;
            else if (wr_rst != 2'b00)
                state_d = CTL_PULSE;
            else
                state_d = CTL_FREE;
        end else begin
            unique case (state_q)
                CTL_FREE:  begin state_d = CTL_FREE;  bits_d = 2'b00;  end
                CTL_PULSE: begin state_d = CTL_FREE;  bits_d = 2'b00;  end
                CTL_HOLD:  begin state_d = CTL_HOLD;  bits_d = bits_q; end
                default:   begin state_d = CTL_FREE;  bits_d = 2'b00;  end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTL_FREE;
            bits_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
        end
    end

    // outputs
    always_comb begin
        rdata          = 8'h00;
        rdata[BIT_SYNC] = (state_q == CTL_HOLD);
        rdata[BIT_AUX]  = bits_q[1];
        rdata[BIT_SHR]  = bits_q[0];
        shr_rst        = bits_q[0];
        aux_rst        = bits_q[1];
    end

endmodule

// File: rtl/tps_prescaler.sv
module tps_prescaler
    import tps_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    output logic [NUM_TAPS-1:0] tap
);

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam int TW = tap_width(i);
        assign tap[i] = !clr && (cnt_q[TW-1:0] == '0);
    end

endmodule

// File: rtl/tps_ext_sync.sv
module tps_ext_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
            rise <= 1'b0;
            fall <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
            rise <= s2_q & ~s3_q;
            fall <= ~s2_q & s3_q;
        end
    end

endmodule

// File: rtl/tps_clk_mux.sv
module tps_clk_mux
    import tps_pkg::*;
(
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_TAPS-1:0] tap,
    input  logic                rise,
    input  logic                fall,
    input  logic                halt,
    output logic                en
);

    logic pick;

    always_comb begin
        unique case (clk_sel_e'(sel))
            SEL_STOP:     pick = 1'b0;
            SEL_CLK:      pick = 1'b1;
            SEL_D8:       pick = tap[0];
            SEL_D64:      pick = tap[1];
            SEL_D256:     pick = tap[2];
            SEL_D1024:    pick = tap[3];
            SEL_EXT_FALL: pick = fall;
            SEL_EXT_RISE: pick = rise;
            default:      pick = 1'b0;
        endcase
        en = pick && !halt;
    end

endmodule

// File: rtl/tmr_prescale_top.sv
module tmr_prescale_top
    import tps_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [7:0]   reg_wdata,
    output logic [7:0]   reg_rdata,
    input  logic [2:0]   clk_sel_a,
    input  logic [2:0]   clk_sel_b,
    input  logic [1:0]   ext_pin,
    output logic [1:0]   cnt_en,
    output logic         aux_pre_rst
);

    logic                shr_rst;
    logic [NUM_TAPS-1:0] tap;
    logic [SEL_W-1:0]    sel_arr [NUM_TMR];
    logic                unused_wbits;

    assign unused_wbits = ^reg_wdata[6:2];
    assign sel_arr[0]   = clk_sel_a;
    assign sel_arr[1]   = clk_sel_b;

    tps_ctrl_fsm u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .wr_sync (reg_wdata[BIT_SYNC]),
        .wr_rst  (reg_wdata[1:0]),
        .rdata   (reg_rdata),
        .shr_rst (shr_rst),
        .aux_rst (aux_pre_rst)
    );

    tps_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (shr_rst),
        .tap   (tap)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        logic rise, fall;

        tps_ext_sync u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_pin[t]),
            .rise  (rise),
            .fall  (fall)
        );

        tps_clk_mux u_mux (
            .sel  (sel_arr[t]),
            .tap  (tap),
            .rise (rise),
            .fall (fall),
            .halt (shr_rst),
            .en   (cnt_en[t])
        );
    end

endmodule

// File: rtl/tps_chk.sv
module tps_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_rdata,
    input logic [2:0] clk_sel_a,
    input logic [2:0] clk_sel_b,
    input logic [1:0] cnt_en
);

    // R2
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:2] == 5'b0);

    // R3
    pulse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[7] && (reg_rdata[1:0] != 2'b00) && !reg_wr) |=> (reg_rdata[1:0] == 2'b00));

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7] && !reg_wr) |=> $stable(reg_rdata));

    // R5
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[0] |-> (cnt_en == 2'b00));

    // R7
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_sel_a == 3'd0) |-> !cnt_en[0]) and ((clk_sel_b == 3'd0) |-> !cnt_en[1]));

    // R8
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel_a[2:1] == 2'b11 && cnt_en[0]) |=> !(clk_sel_a[2:1] == 2'b11 && cnt_en[0]));

endmodule

bind tmr_prescale_top tps_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .clk_sel_a (clk_sel_a),
    .clk_sel_b (clk_sel_b),
    .cnt_en    (cnt_en)
);

// File: tb/tb_tmr_prescale_top.sv
module tb_tmr_prescale_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [2:0] clk_sel_a = 3'd0;
    logic [2:0] clk_sel_b = 3'd0;
    logic [1:0] ext_pin = 2'b00;
    logic [1:0] cnt_en;
    logic       aux_pre_rst;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    tmr_prescale_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .clk_sel_a   (clk_sel_a),
        .clk_sel_b   (clk_sel_b),
        .ext_pin     (ext_pin),
        .cnt_en      (cnt_en),
        .aux_pre_rst (aux_pre_rst)
    );

    // {write byte, read one cycle after, read two cycles after}
    localparam logic [23:0] VEC [8] = '{
        24'h01_01_00, // R3 shared pulse
        24'h02_02_00, // R3 aux pulse
        24'h03_03_00, // R3 both
        24'h7C_00_00, // R2 pad bits ignored
        24'h81_81_81, // R4 hold shared
        24'h83_83_83, // R4 hold both
        24'hFC_80_80, // R2 R4 pad ignored in hold
        24'h00_00_00  // R6 release
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = b;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = 8'h00;
    endtask

    task automatic count(input int n, input int idx, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (cnt_en[idx]) c++;
        end
    endtask

    // toggles both pins every 4 cycles (8 toggles) and counts strobes
    task automatic pin_run(output int ca, output int cb);
        ca = 0;
        cb = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (cnt_en[0]) ca++;
            if (cnt_en[1]) cb++;
            if (k % 4 == 0 && k < 32) ext_pin = ~ext_pin;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c, ca, cb;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
        chk(cnt_en == 2'b00 && !aux_pre_rst, "R1 outputs", {cnt_en, aux_pre_rst}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R2 R3 R4 R6
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][23:16]);
            chk(reg_rdata == VEC[i][15:8], "R2/R3/R4 rdata+1", reg_rdata, VEC[i][15:8]);
            @(negedge clk);
            chk(reg_rdata == VEC[i][7:0], "R2/R3/R4 rdata+2", reg_rdata, VEC[i][7:0]);
        end

        // R7 select codes
        clk_sel_a = 3'd1; count(20, 0, c);   chk(c == 20, "R7 sel1", c, 20);
        clk_sel_a = 3'd0; count(20, 0, c);   chk(c == 0,  "R7 sel0", c, 0);
        clk_sel_a = 3'd2; count(64, 0, c);   chk(c == 8,  "R7 sel2", c, 8);
        clk_sel_a = 3'd3; count(128, 0, c);  chk(c == 2,  "R7 sel3", c, 2);
        clk_sel_b = 3'd4; count(512, 1, c);  chk(c == 2,  "R7 sel4", c, 2);
        clk_sel_b = 3'd5; count(2048, 1, c); chk(c == 2,  "R7 sel5", c, 2);

        // R3 restart timing
        clk_sel_a = 3'd2;
        wr(8'h01);
        chk(cnt_en[0] == 1'b0, "R3 halted during pulse", cnt_en[0], 0);
        @(negedge clk);
        chk(reg_rdata == 8'h00 && cnt_en[0], "R3 tap on clear", {reg_rdata, cnt_en[0]}, 1);

        // R5 hold: nothing counts, external included
        wr(8'h81);
        clk_sel_a = 3'd1; count(16, 0, c); chk(c == 0, "R5 sel1 held", c, 0);
        clk_sel_a = 3'd7; clk_sel_b = 3'd6;
        pin_run(ca, cb);
        chk(ca == 0 && cb == 0, "R5 ext held", ca + cb, 0);

        // R6 simultaneous release
        clk_sel_a = 3'd2; clk_sel_b = 3'd5;
        wr(8'h00);
        chk(cnt_en == 2'b11, "R6 release together", cnt_en, 3);
        @(negedge clk);
        chk(cnt_en == 2'b00, "R6 next cycle quiet", cnt_en, 0);
        repeat (7) @(negedge clk);
        chk(cnt_en == 2'b01, "R6 first d8 after release", cnt_en, 1);

        // R8 edge counting and latency
        clk_sel_a = 3'd7; clk_sel_b = 3'd6;
        ext_pin = 2'b00;
        repeat (6) @(negedge clk);
        pin_run(ca, cb);
        chk(ca == 4, "R8 rising count", ca, 4);
        chk(cb == 4, "R8 falling count", cb, 4);
        ext_pin = 2'b00;
        repeat (6) @(negedge clk);
        ext_pin = 2'b01;
        @(negedge clk);
        @(negedge clk);
        chk(cnt_en[0] == 1'b0, "R8 not after two edges", cnt_en[0], 0);
        @(negedge clk);
        chk(cnt_en[0] == 1'b1, "R8 strobe after three edges", cnt_en[0], 1);
        @(negedge clk);
        chk(cnt_en[0] == 1'b0, "R8 single strobe", cnt_en[0], 0);

        // R9 second prescaler reset
        wr(8'h82);
        repeat (4) @(negedge clk);
        chk(aux_pre_rst == 1'b1, "R9 aux held", aux_pre_rst, 1);
        clk_sel_a = 3'd2; count(64, 0, c);
        chk(c == 8, "R9 timers unaffected", c, 8);
        wr(8'h00);
        chk(aux_pre_rst == 1'b0, "R9 aux released", aux_pre_rst, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule